// File: doc/BRIEF.md
# Cascaded Segment Data Loader

This block fills one display line of segment data into a 160-bit hold register. A controller streams pixel data on a shared parallel bus. Each rising-then-falling transition of the data strobe `xck_i` delivers either a full byte or a half byte. The bus width is chosen by `bus8_i`. Half bytes arrive on `data_i[3:0]`, and two of them are joined into one byte before the byte is written.

Several identical loaders sit on the same bus and form a chain. A line-start pulse on `lp_i` returns every loader to its waiting state. A loader takes bus data only once its chain-enable input is seen low on a strobe falling edge. After that it keeps taking data until all 20 bytes have arrived. It then drives its chain-enable output low for exactly one strobe period, which selects the next loader, and it ignores the bus until the next line-start pulse.

The direction input `dir_i` has two effects. It decides which of the two chain pins is the input and which is the output. It also decides which end of the line is filled first and in which bit order. The strobe is oversampled in the system clock domain: the design recognises a strobe falling edge at the first `clk_i` edge at which `xck_i` is sampled low after being sampled high.

Top module: `seg_loader`

## Requirements
- R1: After reset, `line_o` is all zero and both `eio1_o` and `eio2_o` are high.
- R2: When `dir_i` is 0, `eio1` is the chain output (`eio1_oe_o`=1) and `eio2` is the chain input (`eio2_oe_o`=0). When `dir_i` is 1, the two roles swap. A pin that is not the output drives 1 on its `_o` port.
- R3: When `bus8_i` is 1, each strobe falling edge taken while the loader is selected writes `data_i[7:0]` as one byte. Twenty such edges complete the line.
- R4: When `bus8_i` is 0, each taken falling edge captures `data_i[3:0]`, and bits 7:4 are ignored. The first nibble of a pair becomes byte bits 7:4 and the second becomes byte bits 3:0. A byte is written only on the second nibble, so forty edges complete the line.
- R5: With `dir_i`=0, byte k (k = 0 to 19, counting from the first) is written to `line_o[152-8k+i]` for i = 0 to 7. The first byte therefore lands at bits 159:152 with bit 0 at index 152, and the last byte lands at bits 7:0.
- R6: With `dir_i`=1, byte k bit i is written to `line_o[8k+7-i]`. The first byte therefore lands at bits 7:0 with bit 0 at index 7, and the last byte lands at bits 159:152.
- R7: After a line-start pulse, strobe edges are ignored until one occurs while the chain input is low. That edge is the first edge taken. Once selected, the loader stays selected regardless of the chain input.
- R8: The chain output goes low on the edge that writes the last byte. It returns high on the next strobe falling edge and on no other event except a line-start pulse.
- R9: After the line is complete, further strobe edges leave `line_o` unchanged.
- R10: While `lp_i` is high, the sequencer and any pending half byte are cleared and no write happens. `line_o` keeps its contents, and a new select is needed before data is taken again.
- R11: `line_o` changes only on the `clk_i` edge at which a strobe falling edge is recognised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| xck_i | input | 1 | Data strobe; data is taken on its falling edge |
| lp_i | input | 1 | Line-start pulse; resets the sequencer while high |
| bus8_i | input | 1 | 1: 8-bit bus, 0: 4-bit bus on bits 3:0 |
| dir_i | input | 1 | Direction: chain pin roles and fill order |
| data_i | input | 8 | Display data bus |
| eio1_i | input | 1 | Chain pin 1, input side |
| eio1_o | output | 1 | Chain pin 1, output value |
| eio1_oe_o | output | 1 | Chain pin 1 output enable |
| eio2_i | input | 1 | Chain pin 2, input side |
| eio2_o | output | 1 | Chain pin 2, output value |
| eio2_oe_o | output | 1 | Chain pin 2 output enable |
| line_o | output | 160 | Loaded line; index 0 is the first segment |

## Verification
Four properties are checked on every clock. The first is that exactly one chain pin is enabled as an output. The second is that the chain output falls only on a recognised strobe edge and rises only on such an edge or during a line-start pulse. The third is that the line changes only on a recognised strobe edge. The fourth is that the line is never written while `lp_i` is high.

Some behaviour can only be shown by the bench scenarios:
- the bit placement for each direction and bus width;
- nibble packing, including the clearing of a half byte by a line-start pulse;
- ignoring the bus until the chain input is low;
- the exact one-strobe width of the chain pulse;
- the freeze of the line after it is complete.

// File: rtl/seg_ld_pkg.sv
package seg_ld_pkg;
  localparam int unsigned NUM_SEG_DEF = 160;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned NIB_W       = 4;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/seg_pack.sv
module seg_pack
  import seg_ld_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              take_i,
  input  logic              bus8_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o
);
  logic             half_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      hi_q   <= '0;
    end else if (clr_i) begin
      half_q <= 1'b0;
    end else if (take_i && !bus8_i) begin
      if (!half_q) begin
        hi_q   <= data_i[NIB_W-1:0];
        half_q <= 1'b1;
      end else begin
        half_q <= 1'b0;
      end
    end
  end

  assign byte_vld_o = take_i & (bus8_i | half_q);
  assign byte_o     = bus8_i ? data_i : {hi_q, data_i[NIB_W-1:0]};
endmodule

// File: rtl/seg_chain_ctl.sv
module seg_chain_ctl
  import seg_ld_pkg::*;
#(
  parameter int unsigned NBYTES = NUM_SEG_DEF / BYTE_W,
  localparam int unsigned CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lp_i,
  input  logic             fall_i,
  input  logic             sel_n_i,
  input  logic             byte_vld_i,
  output logic             take_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             eo_n_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  ld_state_e        state_q;
  logic [CNT_W-1:0] idx_q;
  logic             eo_low_q;

  assign take_o = fall_i & ~lp_i &
                  ((state_q == ST_LOAD) | ((state_q == ST_WAIT) & ~sel_n_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT;
      idx_q    <= '0;
      eo_low_q <= 1'b0;
    end else if (lp_i) begin
      state_q  <= ST_WAIT;
      idx_q    <= '0;
      eo_low_q <= 1'b0;
    end else begin
      // hand-off pulse spans exactly one strobe period
      if (eo_low_q && fall_i) eo_low_q <= 1'b0;
      if (take_o) begin
        state_q <= ST_LOAD;
        if (byte_vld_i) begin
          if (idx_q == LAST) begin
            state_q  <= ST_DONE;
            eo_low_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
      end
    end
  end

  assign idx_o  = idx_q;
  assign eo_n_o = ~eo_low_q;
endmodule

// File: rtl/seg_data_latch.sv
module seg_data_latch
  import seg_ld_pkg::*;
#(
  parameter int unsigned NBYTES = NUM_SEG_DEF / BYTE_W,
  localparam int unsigned CNT_W = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int unsigned LINE_W = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              dir_i,
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [LINE_W-1:0] line_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0]  slot;
  logic [BYTE_W-1:0] byte_rev;
  logic [BYTE_W-1:0] byte_wr;

  always_comb begin
    for (int i = 0; i < BYTE_W; i++) byte_rev[i] = byte_i[BYTE_W-1-i];
  end

  // forward fill starts at the top slot, reverse fill at slot 0 with bits mirrored
  assign slot    = dir_i ? idx_i : (LAST - idx_i);
  assign byte_wr = dir_i ? byte_rev : byte_i;

  for (genvar g = 0; g < NBYTES; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_o[g*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_i && (slot == CNT_W'(g))) begin
        line_o[g*BYTE_W +: BYTE_W] <= byte_wr;
      end
    end
  end
endmodule

// File: rtl/seg_loader.sv
module seg_loader
  import seg_ld_pkg::*;
#(
  parameter int unsigned NUM_SEG = NUM_SEG_DEF,
  localparam int unsigned NBYTES = NUM_SEG / BYTE_W,
  localparam int unsigned CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xck_i,
  input  logic               lp_i,
  input  logic               bus8_i,
  input  logic               dir_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic               eio1_i,
  output logic               eio1_o,
  output logic               eio1_oe_o,
  input  logic               eio2_i,
  output logic               eio2_o,
  output logic               eio2_oe_o,
  output logic [NUM_SEG-1:0] line_o
);
  logic              xck_q;
  logic              fall;
  logic              sel_n;
  logic              take;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_d;
  logic [CNT_W-1:0]  idx;
  logic              eo_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xck_q <= 1'b0;
    else         xck_q <= xck_i;
  end

  assign fall  = xck_q & ~xck_i;
  assign sel_n = dir_i ? eio1_i : eio2_i;

  seg_chain_ctl #(.NBYTES(NBYTES)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lp_i       (lp_i),
    .fall_i     (fall),
    .sel_n_i    (sel_n),
    .byte_vld_i (byte_vld),
    .take_o     (take),
    .idx_o      (idx),
    .eo_n_o     (eo_n)
  );

  seg_pack u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (lp_i),
    .take_i     (take),
    .bus8_i     (bus8_i),
    .data_i     (data_i),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_d)
  );

  seg_data_latch #(.NBYTES(NBYTES)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (byte_vld),
    .dir_i  (dir_i),
    .idx_i  (idx),
    .byte_i (byte_d),
    .line_o (line_o)
  );

  assign eio1_oe_o = ~dir_i;
  assign eio2_oe_o = dir_i;
  assign eio1_o    = dir_i ? 1'b1 : eo_n;
  assign eio2_o    = dir_i ? eo_n : 1'b1;
endmodule

// File: rtl/seg_loader_chk.sv
module seg_loader_chk #(
  parameter int unsigned NUM_SEG = 160
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               xck_i,
  input logic               lp_i,
  input logic               dir_i,
  input logic               eio1_o,
  input logic               eio1_oe_o,
  input logic               eio2_o,
  input logic               eio2_oe_o,
  input logic [NUM_SEG-1:0] line_o
);
  logic xck_d;
  logic fall_c;
  logic eo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) xck_d <= 1'b0;
    else         xck_d <= xck_i;
  end

  assign fall_c = xck_d & ~xck_i;
  assign eo     = eio1_oe_o ? eio1_o : eio2_o;

  assert_one_output_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({eio1_oe_o, eio2_oe_o}));

  assert_eo_fall_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(eo) && $stable(dir_i)) |-> ($past(fall_c) && !$past(lp_i)));

  assert_eo_rise_on_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(eo) && $stable(dir_i)) |-> ($past(fall_c) || $past(lp_i)));

  assert_line_on_edge_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(line_o) |-> $past(fall_c));

  assert_no_write_in_lp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lp_i |=> $stable(line_o));
endmodule

bind seg_loader seg_loader_chk #(.NUM_SEG(NUM_SEG)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .xck_i     (xck_i),
  .lp_i      (lp_i),
  .dir_i     (dir_i),
  .eio1_o    (eio1_o),
  .eio1_oe_o (eio1_oe_o),
  .eio2_o    (eio2_o),
  .eio2_oe_o (eio2_oe_o),
  .line_o    (line_o)
);

// File: tb/seg_loader_tb.sv
module seg_loader_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 160;
  localparam int NB = NS / 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          xck_i = 1'b0;
  logic          lp_i = 1'b0;
  logic          bus8_i = 1'b1;
  logic          dir_i = 1'b0;
  logic [7:0]    data_i = '0;
  logic          eio1_i = 1'b1;
  logic          eio2_i = 1'b1;
  logic          eio1_o, eio1_oe_o, eio2_o, eio2_oe_o;
  logic [NS-1:0] line_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [NS-1:0] line;
    logic          eo;
    int            due;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seg_loader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .xck_i(xck_i), .lp_i(lp_i), .bus8_i(bus8_i),
    .dir_i(dir_i), .data_i(data_i), .eio1_i(eio1_i), .eio1_o(eio1_o),
    .eio1_oe_o(eio1_oe_o), .eio2_i(eio2_i), .eio2_o(eio2_o),
    .eio2_oe_o(eio2_oe_o), .line_o(line_o)
  );

  task automatic check(input bit ok, input string tag, input logic [NS-1:0] act,
                       input logic [NS-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare scoreboard items once their due cycle has passed
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      exp_t it;
      logic eo_act;
      it = sb_q.pop_front();
      eo_act = dir_i ? eio2_o : eio1_o;
      check(line_o == it.line, {it.tag, " line"}, line_o, it.line);
      check(eo_act == it.eo, {it.tag, " chain_out"}, NS'(eo_act), NS'(it.eo));
    end
  end

  function automatic logic [NS-1:0] place(input logic [NS-1:0] cur, input int k,
                                          input logic [7:0] b, input bit d);
    logic [NS-1:0] r = cur;
    for (int i = 0; i < 8; i++) begin
      if (!d) r[152 - 8*k + i] = b[i];
      else    r[8*k + 7 - i]   = b[i];
    end
    return r;
  endfunction

  // driver: one strobe period, expected state pushed for the monitor
  task automatic strobe(input logic [7:0] d, input logic [NS-1:0] exp_line,
                        input logic exp_eo, input string tag);
    exp_t it;
    @(negedge clk) xck_i = 1'b1;
    @(negedge clk);
    @(negedge clk) begin
      xck_i  = 1'b0;
      data_i = d;
      it.line = exp_line; it.eo = exp_eo; it.due = cyc + 1; it.tag = tag;
      sb_q.push_back(it);
    end
    @(negedge clk);
  endtask

  task automatic lp_pulse();
    @(negedge clk) lp_i = 1'b1;
    @(negedge clk) lp_i = 1'b0;
  endtask

  task automatic set_sel_n(input logic v);
    if (dir_i) eio1_i = v; else eio2_i = v;
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [NS-1:0] m;
    logic [NS-1:0] saved;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    #1;
    check(line_o == '0, "R1 reset line", line_o, '0);
    check(eio1_o && eio2_o, "R1 reset chain outputs high", NS'({eio1_o, eio2_o}), NS'(2'b11));
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    check(eio1_oe_o && !eio2_oe_o && eio2_o, "R2 roles dir=0",
          NS'({eio1_oe_o, eio2_oe_o, eio2_o}), NS'(3'b101));
    dir_i = 1'b1;
    @(negedge clk);
    check(!eio1_oe_o && eio2_oe_o && eio1_o, "R2 roles dir=1",
          NS'({eio1_oe_o, eio2_oe_o, eio1_o}), NS'(3'b011));

    // 8-bit, dir=0
    dir_i = 1'b0; bus8_i = 1'b1; m = '0;
    lp_pulse();
    strobe(8'hA5, m, 1'b1, "R7 ignored while not selected");
    strobe(8'h3C, m, 1'b1, "R7 ignored while not selected");
    for (int k = 0; k < NB; k++) begin
      b = 8'(8'h11 * k + 8'h07);
      set_sel_n(k == 0 ? 1'b0 : 1'b1);
      m = place(m, k, b, 1'b0);
      strobe(b, m, (k == NB-1) ? 1'b0 : 1'b1, "R3 R5 byte fill dir=0");
    end
    strobe(8'hFF, m, 1'b1, "R8 chain out returns high / R9 frozen");
    strobe(8'h00, m, 1'b1, "R9 frozen after completion");

    // 4-bit, dir=1
    dir_i = 1'b1; bus8_i = 1'b0;
    lp_pulse();
    for (int k = 0; k < NB; k++) begin
      logic [3:0] hi, lo;
      hi = 4'(k + 3); lo = 4'(15 - k);
      set_sel_n(k == 0 ? 1'b0 : 1'b1);
      strobe({4'hF, hi}, m, 1'b1, "R4 first nibble no write");
      set_sel_n(1'b1);
      m = place(m, k, {hi, lo}, 1'b1);
      strobe({4'h9, lo}, m, (k == NB-1) ? 1'b0 : 1'b1, "R4 R6 nibble pair dir=1");
    end
    strobe(8'h0F, m, 1'b1, "R8 R9 after completion dir=1");

    // line-start pulse in mid-line, 4-bit, dir=0
    dir_i = 1'b0; bus8_i = 1'b0;
    lp_pulse();
    set_sel_n(1'b0);
    strobe(8'h0A, m, 1'b1, "R4 nibble a");
    set_sel_n(1'b1);
    m = place(m, 0, 8'hAB, 1'b0);
    strobe(8'h0B, m, 1'b1, "R5 byte after pair");
    strobe(8'h0C, m, 1'b1, "R4 pending nibble");
    saved = m;
    lp_pulse();
    strobe(8'h0D, saved, 1'b1, "R10 line kept, reselect needed");
    set_sel_n(1'b0);
    strobe(8'h0E, saved, 1'b1, "R10 half byte cleared");
    set_sel_n(1'b1);
    m = place(saved, 0, 8'hE6, 1'b0);
    strobe(8'h06, m, 1'b1, "R10 R11 fresh byte at first slot");

    repeat (4) @(negedge clk);
    check(sb_q.size() == 0, "scoreboard drained", NS'(sb_q.size()), '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule